// File: doc/BRIEF.md
# Byte/Halfword Dual-Port RAM

This block is a synchronous RAM whose single storage array is reachable through two independent ports of different widths. One port reads and writes single bytes. The other reads and writes 16-bit halfwords. Each port has its own address, write data, write enable and read data, so both can be used in the same cycle. The halfword port addresses pairs of bytes, so its address is one bit narrower than the byte port's. Its implied byte-address bit 0 is always zero.

Storage is kept as halfwords in two byte lanes. Byte address bit 0 picks the lane in little-endian order: 0 is the low byte and 1 is the high byte. Reads take one cycle on both ports. A port that writes and reads the same place in one cycle returns the contents from before that write.

When both ports write the same halfword in the same cycle, the halfword port wins on both bytes. A read of a byte that the other port is writing in the same cycle returns the old value. Writes to different halfwords in one cycle both take effect.

Top module: `mixed_width_ram`

## Requirements
- R1: While rst_n is low at a rising clock edge, both read outputs are 0 after that edge. Stored contents are not cleared.
- R2: A byte read of address A presents the byte stored at A on bp_rdata just after the rising edge at which A was applied. Read latency is one cycle.
- R3: A halfword write at halfword address H stores hp_wdata[7:0] at byte address 2H and hp_wdata[15:8] at byte address 2H+1.
- R4: A halfword read of H returns {byte at 2H+1, byte at 2H} on hp_rdata, one cycle after H is applied.
- R5: When a port writes and reads the same location in one cycle, its read output for that cycle shows the value from before the write.
- R6: If both ports write within the same halfword in the same cycle, the halfword data is stored in both bytes and the byte-port write is discarded.
- R7: A read on one port of bytes that the other port writes in the same cycle returns the data from before that write.
- R8: Writes from both ports to different halfwords in the same cycle are both stored.
- R9: With a port's write enable low, its write data has no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read outputs |
| bp_addr | input | BYTE_AW | Byte-port byte address |
| bp_we | input | 1 | Byte-port write enable |
| bp_wdata | input | 8 | Byte-port write data |
| bp_rdata | output | 8 | Byte-port read data, one cycle after the address |
| hp_addr | input | BYTE_AW-1 | Halfword-port halfword address |
| hp_we | input | 1 | Halfword-port write enable |
| hp_wdata | input | 16 | Halfword-port write data, low byte at the even byte address |
| hp_rdata | output | 16 | Halfword-port read data, one cycle after the address |

## Verification
Every read result is due exactly one rising edge after its address is applied. Writes become visible to reads issued at the next edge or later. The bench drives a full set of port inputs, waits for one rising edge, and samples both read outputs one time unit later. It compares them against a byte-array model whose contents are taken before that edge's writes are applied, which checks the read-before-write and collision rules in the cycle where they act. Reset is checked in the same way, on the sample taken after the first edge with rst_n low.

// File: rtl/mwram_pkg.sv
// Package: shared widths and helpers for the byte/halfword RAM.
// Assumes exactly two byte lanes per storage word (8-bit and 16-bit ports).
package mwram_pkg;
    localparam int LANE_W   = 8;
    localparam int NUM_LANE = 2;
    localparam int HALF_W   = LANE_W * NUM_LANE;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [HALF_W-1:0] half_t;

    // Return the lane data slice of a halfword for the given lane index.
    function automatic lane_t lane_slice(input half_t hw, input int lane);
        return hw[lane*LANE_W +: LANE_W];
    endfunction
endpackage

// File: rtl/mwram_write_arb.sv
// Module: per-lane write arbitration between the two ports.
// Decides which port writes each lane in a cycle. The halfword port always
// writes both lanes. The byte port writes only its addressed lane, and is
// dropped when the halfword port writes the same halfword in that cycle.
module mwram_write_arb
    import mwram_pkg::*;
#(
    parameter int HALF_AW = 10
) (
    input  logic [HALF_AW-1:0]  bp_half,
    input  logic                bp_lane,
    input  logic                bp_we,
    input  logic [HALF_AW-1:0]  hp_addr,
    input  logic                hp_we,
    output logic [NUM_LANE-1:0] hp_lane_we,
    output logic [NUM_LANE-1:0] bp_lane_we
);
    logic same_half;

    // Detect both ports aiming writes at one halfword.
    always_comb begin
        same_half = hp_we && (hp_addr == bp_half);
    end

    for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
        // Enable each port's write into this lane, halfword port first.
        always_comb begin
            hp_lane_we[g] = hp_we;
            bp_lane_we[g] = bp_we && (bp_lane == 1'(g)) && !same_half;
        end
    end
endmodule

// File: rtl/mwram_lane_bank.sv
// Module: one byte lane of storage with two write and two read ports.
// Each read port registers the old contents of its address every cycle
// (read-before-write). The arbiter guarantees the two write enables never
// target the same entry in one cycle. Reset clears only the read registers.
module mwram_lane_bank
    import mwram_pkg::*;
#(
    parameter int HALF_AW = 10,
    localparam int DEPTH  = 1 << HALF_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HALF_AW-1:0] addr_h,
    input  logic               we_h,
    input  lane_t              wd_h,
    input  logic [HALF_AW-1:0] addr_b,
    input  logic               we_b,
    input  lane_t              wd_b,
    output lane_t              rd_h,
    output lane_t              rd_b
);
    lane_t mem [DEPTH];

    // Apply the writes of both ports to the array.
    always_ff @(posedge clk) begin
        if (we_h) mem[addr_h] <= wd_h;
        if (we_b) mem[addr_b] <= wd_b;
    end

    // Capture the pre-write contents for each port, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_h <= '0;
            rd_b <= '0;
        end else begin
            rd_h <= mem[addr_h];
            rd_b <= mem[addr_b];
        end
    end
endmodule

// File: rtl/mwram_byte_select.sv
// Module: byte-port read lane selection.
// Registers the lane bit alongside the bank reads so the selection lines up
// with the one-cycle read latency.
module mwram_byte_select
    import mwram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lane_in,
    input  lane_t [NUM_LANE-1:0] lane_q,
    output lane_t                byte_out
);
    logic lane_q_sel;

    // Delay the lane select by one cycle to match the bank output.
    always_ff @(posedge clk) begin
        if (!rst_n) lane_q_sel <= 1'b0;
        else        lane_q_sel <= lane_in;
    end

    // Pick the addressed byte from the registered lanes.
    always_comb begin
        byte_out = lane_q[lane_q_sel];
    end
endmodule

// File: rtl/mixed_width_ram.sv
// Module: top of the byte/halfword dual-port RAM.
// Storage is two byte lanes indexed by halfword address. Byte address bit 0
// picks the lane (0 = low byte). The halfword port wins same-halfword write
// collisions. Both ports read with one cycle of latency, old data first.
module mixed_width_ram
    import mwram_pkg::*;
#(
    parameter int BYTE_AW  = 11,
    localparam int HALF_AW = BYTE_AW - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BYTE_AW-1:0] bp_addr,
    input  logic               bp_we,
    input  logic [7:0]         bp_wdata,
    output logic [7:0]         bp_rdata,
    input  logic [HALF_AW-1:0] hp_addr,
    input  logic               hp_we,
    input  logic [15:0]        hp_wdata,
    output logic [15:0]        hp_rdata
);
    logic [HALF_AW-1:0]   bp_half;
    logic                 bp_lane;
    logic [NUM_LANE-1:0]  hp_lane_we;
    logic [NUM_LANE-1:0]  bp_lane_we;
    lane_t [NUM_LANE-1:0] rd_h_lane;
    lane_t [NUM_LANE-1:0] rd_b_lane;

    // Split the byte address into halfword index and lane.
    always_comb begin
        bp_half = bp_addr[BYTE_AW-1:1];
        bp_lane = bp_addr[0];
    end

    mwram_write_arb #(.HALF_AW(HALF_AW)) u_arb (
        .bp_half    (bp_half),
        .bp_lane    (bp_lane),
        .bp_we      (bp_we),
        .hp_addr    (hp_addr),
        .hp_we      (hp_we),
        .hp_lane_we (hp_lane_we),
        .bp_lane_we (bp_lane_we)
    );

    for (genvar g = 0; g < NUM_LANE; g++) begin : g_bank
        mwram_lane_bank #(.HALF_AW(HALF_AW)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .addr_h (hp_addr),
            .we_h   (hp_lane_we[g]),
            .wd_h   (lane_slice(hp_wdata, g)),
            .addr_b (bp_half),
            .we_b   (bp_lane_we[g]),
            .wd_b   (bp_wdata),
            .rd_h   (rd_h_lane[g]),
            .rd_b   (rd_b_lane[g])
        );
    end

    mwram_byte_select u_bsel (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_in  (bp_lane),
        .lane_q   (rd_b_lane),
        .byte_out (bp_rdata)
    );

    // Assemble the halfword read, lane 0 in the low byte.
    always_comb begin
        hp_rdata = rd_h_lane;
    end
endmodule

// File: rtl/mwram_checker.sv
// Module: temporal checks on the RAM ports, bound to the top module.
// Assumes write enables are low while reset is held.
module mwram_checker #(
    parameter int BYTE_AW  = 11,
    localparam int HALF_AW = BYTE_AW - 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [BYTE_AW-1:0] bp_addr,
    input logic               bp_we,
    input logic [7:0]         bp_wdata,
    input logic [7:0]         bp_rdata,
    input logic [HALF_AW-1:0] hp_addr,
    input logic               hp_we,
    input logic [15:0]        hp_wdata,
    input logic [15:0]        hp_rdata
);
    // R1: reset clears both read outputs.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (bp_rdata == 8'h00 && hp_rdata == 16'h0000));

    // R3: a halfword write reads back intact at the next idle read of it.
    a_r3_half_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hp_we) && !hp_we && !bp_we && hp_addr == $past(hp_addr))
        |=> hp_rdata == $past(hp_wdata, 2));

    // R2: a byte write alone reads back on the byte port.
    a_r2_byte_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bp_we) && !$past(hp_we) && !hp_we && !bp_we
         && bp_addr == $past(bp_addr))
        |=> bp_rdata == $past(bp_wdata, 2));

    // R5: a halfword write returns the old contents on its own port.
    a_r5_half_old_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(hp_we) && !$past(bp_we) && hp_we
         && hp_addr == $past(hp_addr))
        |=> $stable(hp_rdata));

    // R7: a byte read of a halfword being written returns the old byte.
    a_r7_byte_sees_old: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(hp_we) && !$past(bp_we) && hp_we && !bp_we
         && hp_addr == bp_addr[BYTE_AW-1:1] && bp_addr == $past(bp_addr))
        |=> $stable(bp_rdata));
endmodule

bind mixed_width_ram mwram_checker #(.BYTE_AW(BYTE_AW)) u_mwram_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bp_addr  (bp_addr),
    .bp_we    (bp_we),
    .bp_wdata (bp_wdata),
    .bp_rdata (bp_rdata),
    .hp_addr  (hp_addr),
    .hp_we    (hp_we),
    .hp_wdata (hp_wdata),
    .hp_rdata (hp_rdata)
);

// File: tb/test_mixed_width_ram.sv
// Directed bench for the byte/halfword RAM against a byte-array model.
module test_mixed_width_ram;
    localparam int BYTE_AW = 11;
    localparam int HALF_AW = BYTE_AW - 1;
    localparam int NBYTE   = 1 << BYTE_AW;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [BYTE_AW-1:0] bp_addr = '0;
    logic               bp_we = 1'b0;
    logic [7:0]         bp_wdata = '0;
    logic [7:0]         bp_rdata;
    logic [HALF_AW-1:0] hp_addr = '0;
    logic               hp_we = 1'b0;
    logic [15:0]        hp_wdata = '0;
    logic [15:0]        hp_rdata;

    logic [7:0] model [NBYTE];
    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mixed_width_ram #(.BYTE_AW(BYTE_AW)) i_mixed_width_ram (
        .clk(clk), .rst_n(rst_n),
        .bp_addr(bp_addr), .bp_we(bp_we), .bp_wdata(bp_wdata), .bp_rdata(bp_rdata),
        .hp_addr(hp_addr), .hp_we(hp_we), .hp_wdata(hp_wdata), .hp_rdata(hp_rdata)
    );

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s byte port: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s halfword port: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive both ports, sample after the edge, then update the model.
    task automatic step(string tag, bit chk,
                        logic [BYTE_AW-1:0] ba, logic bw, logic [7:0] bd,
                        logic [HALF_AW-1:0] ha, logic hw, logic [15:0] hd);
        logic [7:0]  exp_b;
        logic [15:0] exp_h;
        bp_addr = ba; bp_we = bw; bp_wdata = bd;
        hp_addr = ha; hp_we = hw; hp_wdata = hd;
        exp_b = model[ba];
        exp_h = {model[{ha, 1'b1}], model[{ha, 1'b0}]};
        @(posedge clk);
        #1;
        if (chk) begin
            check8(tag, bp_rdata, exp_b);
            check16(tag, hp_rdata, exp_h);
        end
        if (hw) begin
            model[{ha, 1'b0}] = hd[7:0];
            model[{ha, 1'b1}] = hd[15:8];
        end
        if (bw && !(hw && ha == ba[BYTE_AW-1:1])) model[ba] = bd;
        bp_we = 1'b0;
        hp_we = 1'b0;
    endtask

    // Fill all storage through the halfword port so the model is defined.
    task automatic t_fill();
        for (int i = 0; i < NBYTE / 2; i++)
            step("R3", 1'b0, '0, 1'b0, 8'h00, HALF_AW'(i), 1'b1, 16'(i * 16'h0101 + 16'h3c5a));
    endtask

    // R1: reset clears read outputs but keeps contents.
    task automatic t_reset();
        rst_n = 1'b0;
        bp_addr = 11'h005;
        hp_addr = 10'h003;
        @(posedge clk);
        #1;
        check8("R1", bp_rdata, 8'h00);
        check16("R1", hp_rdata, 16'h0000);
        rst_n = 1'b1;
        step("R1", 1'b1, 11'h005, 1'b0, 8'h00, 10'h003, 1'b0, 16'h0);
    endtask

    // R2/R4: byte writes then reads, checked on both ports.
    task automatic t_byte_rw();
        step("R2", 1'b1, 11'h010, 1'b1, 8'hA1, 10'h040, 1'b0, 16'h0);
        step("R2", 1'b1, 11'h011, 1'b1, 8'hB2, 10'h008, 1'b0, 16'h0);
        step("R2", 1'b1, 11'h010, 1'b0, 8'h00, 10'h008, 1'b0, 16'h0);
        step("R4", 1'b1, 11'h011, 1'b0, 8'h00, 10'h008, 1'b0, 16'h0);
        check16("R4", hp_rdata, 16'hB2A1);
    endtask

    // R3: halfword write lands little-endian in the byte view.
    task automatic t_half_layout();
        step("R3", 1'b1, 11'h000, 1'b0, 8'h00, 10'h020, 1'b1, 16'hBEEF);
        step("R3", 1'b1, 11'h040, 1'b0, 8'h00, 10'h020, 1'b0, 16'h0);
        check8("R3", bp_rdata, 8'hEF);
        step("R3", 1'b1, 11'h041, 1'b0, 8'h00, 10'h020, 1'b0, 16'h0);
        check8("R3", bp_rdata, 8'hBE);
    endtask

    // R5: read-before-write on each port's own location.
    task automatic t_rbw();
        step("R5", 1'b1, 11'h030, 1'b0, 8'h00, 10'h030, 1'b0, 16'h0);
        step("R5", 1'b1, 11'h030, 1'b1, 8'h77, 10'h030, 1'b1, 16'h1234);
        step("R5", 1'b1, 11'h031, 1'b1, 8'h99, 10'h031, 1'b0, 16'h0);
        step("R5", 1'b1, 11'h031, 1'b0, 8'h00, 10'h030, 1'b0, 16'h0);
        check8("R5", bp_rdata, 8'h99);
    endtask

    // R6: same-halfword write collision, halfword data wins.
    task automatic t_collide_write();
        step("R6", 1'b1, 11'h051, 1'b1, 8'h55, 10'h028, 1'b1, 16'hCAFE);
        step("R6", 1'b1, 11'h051, 1'b0, 8'h00, 10'h028, 1'b0, 16'h0);
        check8("R6", bp_rdata, 8'hCA);
        check16("R6", hp_rdata, 16'hCAFE);
    endtask

    // R7: cross-port reads during the other port's write return old data.
    task automatic t_cross_read();
        step("R7", 1'b1, 11'h060, 1'b0, 8'h00, 10'h030, 1'b1, 16'h0F0F);
        step("R7", 1'b1, 11'h060, 1'b1, 8'h6E, 10'h030, 1'b0, 16'h0);
        step("R7", 1'b1, 11'h060, 1'b0, 8'h00, 10'h030, 1'b0, 16'h0);
        check8("R7", bp_rdata, 8'h6E);
    endtask

    // R8: writes to distinct halfwords in one cycle both land.
    task automatic t_disjoint();
        step("R8", 1'b1, 11'h071, 1'b1, 8'h3D, 10'h070, 1'b1, 16'h4242);
        step("R8", 1'b1, 11'h071, 1'b0, 8'h00, 10'h070, 1'b0, 16'h0);
        check8("R8", bp_rdata, 8'h3D);
        check16("R8", hp_rdata, 16'h4242);
    endtask

    // R9: data with enables low changes nothing.
    task automatic t_we_low();
        step("R9", 1'b1, 11'h090, 1'b1, 8'h11, 10'h048, 1'b1, 16'h2233);
        step("R9", 1'b1, 11'h090, 1'b0, 8'hEE, 10'h048, 1'b0, 16'hDDCC);
        step("R9", 1'b1, 11'h090, 1'b0, 8'h00, 10'h048, 1'b0, 16'h0);
        check8("R9", bp_rdata, 8'h33);
        check16("R9", hp_rdata, 16'h2233);
    endtask

    // R2-style mixed random traffic on a small window to force collisions.
    task automatic t_random();
        for (int i = 0; i < 2000; i++)
            step("R7", 1'b1, BYTE_AW'($urandom_range(0, 15)), 1'($urandom),
                 8'($urandom), HALF_AW'($urandom_range(0, 7)), 1'($urandom),
                 16'($urandom));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                done = 1'b1;
                failures++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_fill();
        t_reset();
        t_byte_rw();
        t_half_layout();
        t_rbw();
        t_collide_write();
        t_cross_read();
        t_disjoint();
        t_we_low();
        t_random();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule